// File: doc/BRIEF.md
# Host-to-Controller Mailbox

This block sits between a host bus and a small embedded controller and gives the two sides a shared exchange point built from three registers. The host, through chip select, read strobe, write strobe, one address line and an 8-bit data bus, writes bytes into an inbound register and reads bytes back from an outbound register. Both sides can see a status byte that combines hardware full flags with bits the controller sets itself.

A host write always lands in the inbound register. The address line is captured with each write, so the controller can tell a command byte from a data byte. The controller reads the inbound byte, loads the outbound byte and writes its own status bits. It can also be interrupted with a single-cycle request each time the host writes, if it has enabled that. All timing is synchronous to one clock. Host strobes are detected on their rising edge, so a strobe held for several cycles counts as one access.

Top module: `host_mailbox`

## Requirements
- R1: After a synchronous reset, both buffers, the status byte and the interrupt request are 0, and `host_rdata_o` is 0x00.
- R2: On a rising edge of (`cs_i` & `wr_i`), the inbound buffer takes `host_wdata_i`, status bit 1 (inbound full) sets, and status bit 3 (command flag) takes `a0_i` (1 = command, 0 = data); all are visible one cycle later. A strobe held high counts as one write.
- R3: While `cs_i` & `rd_i` is high, `host_rdata_o` shows the status byte when `a0_i` = 1 and the outbound buffer when `a0_i` = 0; otherwise it is 0x00.
- R4: A host status read (`a0_i` = 1) changes no state.
- R5: Status bit 0 (outbound full) sets on `loc_load_i` and clears one cycle after a rising edge of (`cs_i` & `rd_i`) taken with `a0_i` = 0; a local load in the same cycle wins and the bit stays set.
- R6: Status bit 1 clears one cycle after `loc_take_i`; a host write edge in the same cycle wins and the bit stays set.
- R7: A host write while inbound full, or a local load while outbound full, overwrites the buffer with no error indication.
- R8: `usr_we_i` copies `usr_bits_i` bits 2 and 7:4 into the same status positions; its bits 0, 1 and 3 have no effect.
- R9: `irq_o` is high for exactly one cycle, the cycle after a host write edge, and only if `irq_en_i` was high at that edge.
- R10: `status_o` presents to the controller the same byte the host reads from status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Host chip select |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| a0_i | input | 1 | Host address bit |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data |
| loc_take_i | input | 1 | Controller has consumed the inbound byte |
| loc_inbuf_o | output | 8 | Inbound buffer contents |
| loc_load_i | input | 1 | Controller loads the outbound byte |
| loc_wdata_i | input | 8 | Outbound byte to load |
| usr_we_i | input | 1 | Controller writes user status bits |
| usr_bits_i | input | 8 | User status value |
| irq_en_i | input | 1 | Interrupt enable from the controller |
| irq_o | output | 1 | Interrupt request pulse |
| status_o | output | 8 | Status byte seen by the controller |

## Verification
Directed sequences first try held write strobes with the interrupt on and off, which separates edge detection and gating from level-sensitive behaviour. Then they try back-to-back writes and loads that overwrite full buffers, status reads placed between data reads to show that reading status consumes nothing, and same-cycle collisions of host and local accesses, which show which side wins. A long stretch of random strobes, address values and local actions is then compared each cycle against a behavioural model. This catches ordering faults that the directed cases would miss.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DATA_W = 8;

    localparam int ST_OBF = 0;
    localparam int ST_IBF = 1;
    localparam int ST_U2  = 2;
    localparam int ST_CD  = 3;

    typedef struct packed {
        logic [3:0] usr_hi;
        logic       cmd;
        logic       usr_lo;
        logic       in_full;
        logic       out_full;
    } mbx_status_t;

    typedef struct packed {
        logic wr_evt;
        logic rd_out_evt;
        logic a0;
    } host_evt_t;

    function automatic mbx_status_t make_status(input logic [4:0] usr,
                                                input logic cmd,
                                                input logic ibf,
                                                input logic obf);
        mbx_status_t s;
        s.usr_hi   = usr[4:1];
        s.cmd      = cmd;
        s.usr_lo   = usr[0];
        s.in_full  = ibf;
        s.out_full = obf;
        return s;
    endfunction
endpackage

// File: rtl/mbx_host_port.sv
module mbx_host_port
    import mbx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_i,
    input  logic      rd_i,
    input  logic      wr_i,
    input  logic      a0_i,
    output host_evt_t evt_o
);
    logic wr_lvl, rd_lvl, wr_q, rd_q;

    assign wr_lvl = cs_i & wr_i;
    assign rd_lvl = cs_i & rd_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_lvl;
            rd_q <= rd_lvl;
        end
    end

    always_comb begin
        evt_o.wr_evt     = wr_lvl & ~wr_q;
        evt_o.rd_out_evt = rd_lvl & ~rd_q & ~a0_i;
        evt_o.a0         = a0_i;
    end

    p_wr_single_r2: assert property (@(posedge clk) disable iff (rst)
        evt_o.wr_evt |=> !evt_o.wr_evt);
endmodule

// File: rtl/mbx_in_reg.sv
module mbx_in_reg
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  host_evt_t         evt_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              take_i,
    input  logic              irq_en_i,
    output logic [DATA_W-1:0] buf_o,
    output logic              full_o,
    output logic              cmd_o,
    output logic              irq_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_o  <= '0;
            full_o <= 1'b0;
            cmd_o  <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            irq_o <= evt_i.wr_evt & irq_en_i;
            if (evt_i.wr_evt) begin
                buf_o  <= wdata_i;
                cmd_o  <= evt_i.a0;
                full_o <= 1'b1;
            end else if (take_i) begin
                full_o <= 1'b0;
            end
        end
    end

    p_ibf_set_r2: assert property (@(posedge clk) disable iff (rst)
        evt_i.wr_evt |=> (full_o && cmd_o == $past(evt_i.a0) && buf_o == $past(wdata_i)));
    p_ibf_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (take_i && !evt_i.wr_evt) |=> !full_o);
    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);
    p_irq_full_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> full_o);
endmodule

// File: rtl/mbx_out_reg.sv
module mbx_out_reg
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  host_evt_t         evt_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] ldata_i,
    output logic [DATA_W-1:0] buf_o,
    output logic              full_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_o  <= '0;
            full_o <= 1'b0;
        end else if (load_i) begin
            buf_o  <= ldata_i;
            full_o <= 1'b1;
        end else if (evt_i.rd_out_evt) begin
            full_o <= 1'b0;
        end
    end

    p_obf_set_r5: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (full_o && buf_o == $past(ldata_i)));
    p_obf_clr_r5: assert property (@(posedge clk) disable iff (rst)
        (evt_i.rd_out_evt && !load_i) |=> !full_o);
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic              a0_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic [DATA_W-1:0] host_rdata_o,
    input  logic              loc_take_i,
    output logic [DATA_W-1:0] loc_inbuf_o,
    input  logic              loc_load_i,
    input  logic [DATA_W-1:0] loc_wdata_i,
    input  logic              usr_we_i,
    input  logic [DATA_W-1:0] usr_bits_i,
    input  logic              irq_en_i,
    output logic              irq_o,
    output logic [DATA_W-1:0] status_o
);
    host_evt_t         evt;
    logic [DATA_W-1:0] obuf;
    logic              ibf, obf, cmd;
    logic [4:0]        usr_q;
    mbx_status_t       st;

    mbx_host_port u_port (
        .clk(clk), .rst(rst), .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i),
        .a0_i(a0_i), .evt_o(evt)
    );

    mbx_in_reg u_in (
        .clk(clk), .rst(rst), .evt_i(evt), .wdata_i(host_wdata_i),
        .take_i(loc_take_i), .irq_en_i(irq_en_i), .buf_o(loc_inbuf_o),
        .full_o(ibf), .cmd_o(cmd), .irq_o(irq_o)
    );

    mbx_out_reg u_out (
        .clk(clk), .rst(rst), .evt_i(evt), .load_i(loc_load_i),
        .ldata_i(loc_wdata_i), .buf_o(obuf), .full_o(obf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            usr_q <= '0;
        end else if (usr_we_i) begin
            usr_q <= {usr_bits_i[7:4], usr_bits_i[ST_U2]};
        end
    end

    assign st       = make_status(usr_q, cmd, ibf, obf);
    assign status_o = st;

    always_comb begin
        if (cs_i && rd_i) host_rdata_o = a0_i ? st : obuf;
        else              host_rdata_o = '0;
    end

    p_stat_read_nosfx_r4: assert property (@(posedge clk) disable iff (rst)
        (cs_i && rd_i && a0_i && !evt.wr_evt && !loc_take_i && !loc_load_i && !usr_we_i)
        |=> $stable(status_o));
    p_usr_hw_bits_r8: assert property (@(posedge clk) disable iff (rst)
        (usr_we_i && !evt.wr_evt && !loc_take_i && !loc_load_i && !evt.rd_out_evt)
        |=> (status_o[ST_OBF] == $past(status_o[ST_OBF]) &&
             status_o[ST_IBF] == $past(status_o[ST_IBF]) &&
             status_o[ST_CD]  == $past(status_o[ST_CD])));
endmodule

// File: tb/host_mailbox_bench.sv
module host_mailbox_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 0, rd = 0, wr = 0, a0 = 0;
    logic [7:0] hwd = 0, lwd = 0, ubits = 0;
    logic       ltake = 0, lload = 0, uwe = 0, ien = 0;
    logic [7:0] hrd, inbuf, stat;
    logic       irq;

    int checks = 0, fails = 0, irq_cnt = 0;
    bit done = 0;

    int m_ibuf, m_obuf, m_ibf, m_obf, m_cd, m_usr, m_irq, m_pw, m_pr;

    always #4 clk = ~clk;

    host_mailbox u_host_mailbox (
        .clk(clk), .rst(rst), .cs_i(cs), .rd_i(rd), .wr_i(wr), .a0_i(a0),
        .host_wdata_i(hwd), .host_rdata_o(hrd), .loc_take_i(ltake),
        .loc_inbuf_o(inbuf), .loc_load_i(lload), .loc_wdata_i(lwd),
        .usr_we_i(uwe), .usr_bits_i(ubits), .irq_en_i(ien), .irq_o(irq),
        .status_o(stat)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int m_status();
        return (m_usr & 8'hF4) | (m_cd << 3) | (m_ibf << 1) | m_obf;
    endfunction

    function automatic int m_hrd();
        if (cs && rd) return a0 ? m_status() : m_obuf;
        return 0;
    endfunction

    task automatic model_reset();
        m_ibuf = 0; m_obuf = 0; m_ibf = 0; m_obf = 0; m_cd = 0;
        m_usr = 0; m_irq = 0; m_pw = 0; m_pr = 0;
    endtask

    // one clock: model advances at the edge, outputs compared at the falling edge
    task automatic step();
        int w, r, wev, rev;
        @(posedge clk);
        if (rst) model_reset();
        else begin
            w = cs && wr; r = cs && rd;
            wev = w && !m_pw; rev = r && !m_pr && !a0;
            m_irq = wev && ien;
            if (wev) begin m_ibuf = hwd; m_cd = a0; m_ibf = 1; end
            else if (ltake) m_ibf = 0;
            if (lload) begin m_obuf = lwd; m_obf = 1; end
            else if (rev) m_obf = 0;
            if (uwe) m_usr = ubits & 8'hF4;
            m_pw = w; m_pr = r;
        end
        @(negedge clk);
        if (irq) irq_cnt++;
        check(hrd == 8'(m_hrd()), "R3 read data", hrd, m_hrd());
        check(stat == 8'(m_status()), "R10 status", stat, m_status());
        check(irq == 1'(m_irq), "R9 irq", irq, m_irq);
        check(inbuf == 8'(m_ibuf), "R2 inbuf", inbuf, m_ibuf);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic hwrite(input logic a, input logic [7:0] d, input int hold);
        cs = 1; wr = 1; a0 = a; hwd = d;
        idle(hold);
        cs = 0; wr = 0;
        step();
    endtask

    task automatic hread(input logic a, output logic [7:0] d);
        cs = 1; rd = 1; a0 = a;
        #1 d = hrd;
        step();
        cs = 0; rd = 0;
        step();
    endtask

    initial begin
        logic [7:0] v;
        int c0;
        idle(2);
        rst = 0;
        step();
        check(stat == 8'h00 && hrd == 8'h00 && !irq && inbuf == 8'h00, "R1 reset", stat, 0);

        ien = 1; c0 = irq_cnt;
        hwrite(1'b1, 8'hA5, 3);
        check(inbuf == 8'hA5, "R2 write data", inbuf, 8'hA5);
        check(stat == 8'h0A, "R2 ibf+cmd", stat, 8'h0A);
        check(irq_cnt - c0 == 1, "R9 one pulse on held strobe", irq_cnt - c0, 1);

        ltake = 1; step(); ltake = 0; step();
        check(stat == 8'h08, "R6 ibf cleared", stat, 8'h08);

        ien = 0; c0 = irq_cnt;
        hwrite(1'b0, 8'h3C, 1);
        check(stat == 8'h02, "R2 data flag", stat, 8'h02);
        check(irq_cnt == c0, "R9 gated off", irq_cnt - c0, 0);
        hwrite(1'b0, 8'h77, 1);
        check(inbuf == 8'h77 && stat == 8'h02, "R7 inbound overwrite", inbuf, 8'h77);

        lload = 1; lwd = 8'h11; step();
        lwd = 8'h22; step(); lload = 0; step();
        check(stat == 8'h03, "R5 obf set", stat, 8'h03);
        hread(1'b1, v);
        check(v == 8'h03, "R3 status read", v, 8'h03);
        check(stat == 8'h03, "R4 status read no side effect", stat, 8'h03);
        hread(1'b0, v);
        check(v == 8'h22, "R7 outbound overwrite", v, 8'h22);
        check(stat == 8'h02, "R5 obf cleared by read", stat, 8'h02);

        uwe = 1; ubits = 8'hFF; step(); uwe = 0; step();
        check(stat == 8'hF6, "R8 user bits", stat, 8'hF6);
        uwe = 1; ubits = 8'h0B; step(); uwe = 0; step();
        check(stat == 8'h02, "R8 hw bits ignored", stat, 8'h02);

        ltake = 1; cs = 1; wr = 1; a0 = 0; hwd = 8'h5E; step();
        ltake = 0; cs = 0; wr = 0; step();
        check(stat[1] == 1'b1 && inbuf == 8'h5E, "R6 write wins over take", stat, 8'h02);
        lload = 1; lwd = 8'h9D; cs = 1; rd = 1; a0 = 0; step();
        lload = 0; cs = 0; rd = 0; step();
        check(stat[0] == 1'b1, "R5 load wins over read", stat[0], 1);

        for (int i = 0; i < 3000; i++) begin
            cs = 1'($urandom); rd = 1'($urandom); wr = 1'($urandom);
            a0 = 1'($urandom); hwd = 8'($urandom);
            ltake = ($urandom % 4) == 0; lload = ($urandom % 4) == 0;
            lwd = 8'($urandom); uwe = ($urandom % 8) == 0; ubits = 8'($urandom);
            ien = 1'($urandom);
            step();
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule